// File: doc/BRIEF.md
# Priority Interrupt Arbiter

This block chooses which of sixteen interrupt sources the CPU should service next. There are three groups of sources: one non-maskable external line, seven maskable external lines and eight on-chip peripheral sources. Each source carries a pending flag. Each maskable source also carries a programmed 3-bit level. A pending source with a non-zero level competes if its level is above the CPU's current mask, or if its level is 7. The highest level wins. When several candidates share that level, a fixed source order breaks the tie. The block registers the result and presents three things: a request flag, the winning level, and an auto-vector number. External sources and on-chip sources draw their vectors from two separate tables.

The CPU raises a one-cycle take strobe when it accepts the request. The block then computes the mask value that the CPU loads for the handler. In nesting mode this is the serviced level. In flat mode it is 7, so only level-7 requests can interrupt the handler. Edge detection on the pins and the register interface belong to neighbouring blocks.

Top module: `irq_prio_arbiter`

## Requirements
- R1: Source index 15 is the non-maskable line, 14 down to 8 are the maskable external lines, and 7 down to 0 are the on-chip sources. The on-chip sources in descending index order are two-wire bus, converter, serial-1 receive, serial-1 transmit, serial-0 receive, serial-0 transmit, timer 1 and timer 0. Field `lvl_i[3*i+2:3*i]` holds the level of source i for i from 0 to 14.
- R2: A source whose level is 0 never produces a request, even when it is pending.
- R3: A pending source competes only when its level is strictly greater than `mask_i`, or when its level is 7.
- R4: Among the competing sources, the one with the highest level wins.
- R5: When competing sources share the highest level, the source with the larger index wins.
- R6: Source 15 always has level 7 and no level field. When it is pending it wins, whatever the mask is.
- R7: When an external source (index 8 to 15) wins, `req_vec_o` equals 24 plus the winning level.
- R8: When an on-chip source (index 0 to 7) wins, `req_vec_o` equals 56 plus the winning level.
- R9: The request flag, level and vector are registered and follow the inputs one clock later. When no source competes, all three are 0.
- R10: A take strobe while `req_o` is high with `nest_mode_i` = 1 makes `new_mask_o` equal the presented level after that edge.
- R11: A take strobe while `req_o` is high with `nest_mode_i` = 0 makes `new_mask_o` equal 7 after that edge.
- R12: `new_mask_o` changes only on a take strobe while `req_o` is high. Reset sets it to 7 and sets `req_o`, `req_lvl_o` and `req_vec_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_i | input | 16 | Pending flag per source, index order per R1 |
| lvl_i | input | 45 | 3-bit level for sources 0..14 |
| mask_i | input | 3 | CPU's current interrupt mask |
| nest_mode_i | input | 1 | 1: take loads the serviced level; 0: take loads 7 |
| take_i | input | 1 | CPU accepts the presented request (one-cycle strobe) |
| req_o | output | 1 | A request is presented |
| req_lvl_o | output | 3 | Level of the presented request |
| req_vec_o | output | 8 | Auto-vector number of the presented request |
| new_mask_o | output | 3 | Mask value the CPU loads for the handler |

## Verification
The request flag, level and vector are due one rising edge after the inputs that produce them. The new mask is due one rising edge after the take strobe, and it is built from the winner that was registered before that strobe. The bench changes every input on the falling edge and samples all outputs 1 ns after the next rising edge. It carries the winner it expects from the previous step forward, and uses it to predict the effect of a take in the current step.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
    localparam int LVL_W        = 3;
    localparam int VEC_W        = 8;
    localparam int EXT_VEC_BASE = 24;
    localparam int ONC_VEC_BASE = 56;

    typedef struct packed {
        logic             req;
        logic [LVL_W-1:0] lvl;
        logic [VEC_W-1:0] vec;
        logic [LVL_W-1:0] mask;
    } arb_state_t;
endpackage

// File: rtl/irq_src_qualify.sv
module irq_src_qualify
    import irq_arb_pkg::*;
#(
    parameter int N_SRC = 16
) (
    input  logic [N_SRC-1:0]           pend_i,
    input  logic [(N_SRC-1)*LVL_W-1:0] lvl_i,
    input  logic [LVL_W-1:0]           mask_i,
    output logic [N_SRC-1:0]           elig_o,
    output logic [N_SRC*LVL_W-1:0]     eff_lvl_o
);
    localparam logic [LVL_W-1:0] TOP_LVL = '1;

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        logic [LVL_W-1:0] lvl_w;
        if (g == N_SRC - 1) begin : g_fixed
            // the non-maskable line has a hardwired top level
            assign lvl_w = TOP_LVL;
        end else begin : g_prog
            assign lvl_w = lvl_i[g*LVL_W +: LVL_W];
        end
        assign eff_lvl_o[g*LVL_W +: LVL_W] = lvl_w;
        assign elig_o[g] = pend_i[g] && (lvl_w != '0)
                           && ((lvl_w > mask_i) || (lvl_w == TOP_LVL));
    end
endmodule

// File: rtl/irq_winner_pick.sv
module irq_winner_pick
    import irq_arb_pkg::*;
#(
    parameter int N_SRC = 16,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0]       elig_i,
    input  logic [N_SRC*LVL_W-1:0] eff_lvl_i,
    output logic                   found_o,
    output logic [IDX_W-1:0]       win_idx_o,
    output logic [LVL_W-1:0]       win_lvl_o
);
    // ascending scan with >= lets a larger index take over on equal level
    always_comb begin
        found_o   = 1'b0;
        win_idx_o = '0;
        win_lvl_o = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (elig_i[i] && (eff_lvl_i[i*LVL_W +: LVL_W] >= win_lvl_o)) begin
                found_o   = 1'b1;
                win_idx_o = IDX_W'(i);
                win_lvl_o = eff_lvl_i[i*LVL_W +: LVL_W];
            end
        end
    end
endmodule

// File: rtl/irq_vector_map.sv
module irq_vector_map
    import irq_arb_pkg::*;
#(
    parameter int N_SRC = 16,
    parameter int N_EXT = 8,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic [IDX_W-1:0] win_idx_i,
    input  logic [LVL_W-1:0] win_lvl_i,
    output logic [VEC_W-1:0] vec_o
);
    localparam logic [IDX_W-1:0] FIRST_EXT = IDX_W'(N_SRC - N_EXT);

    logic is_ext;
    assign is_ext = (win_idx_i >= FIRST_EXT);
    assign vec_o  = (is_ext ? VEC_W'(EXT_VEC_BASE) : VEC_W'(ONC_VEC_BASE))
                    + VEC_W'(win_lvl_i);
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
    import irq_arb_pkg::*;
#(
    parameter int N_SRC = 16,
    parameter int N_EXT = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_SRC-1:0]           pend_i,
    input  logic [(N_SRC-1)*LVL_W-1:0] lvl_i,
    input  logic [LVL_W-1:0]           mask_i,
    input  logic                       nest_mode_i,
    input  logic                       take_i,
    output logic                       req_o,
    output logic [LVL_W-1:0]           req_lvl_o,
    output logic [VEC_W-1:0]           req_vec_o,
    output logic [LVL_W-1:0]           new_mask_o
);
    localparam int IDX_W = $clog2(N_SRC);
    localparam logic [LVL_W-1:0] TOP_LVL = '1;

    logic [N_SRC-1:0]       elig;
    logic [N_SRC*LVL_W-1:0] eff_lvl;
    logic                   found;
    logic [IDX_W-1:0]       win_idx;
    logic [LVL_W-1:0]       win_lvl;
    logic [VEC_W-1:0]       win_vec;

    arb_state_t st_d, st_q;

    irq_src_qualify #(.N_SRC(N_SRC)) u_qual (
        .pend_i    (pend_i),
        .lvl_i     (lvl_i),
        .mask_i    (mask_i),
        .elig_o    (elig),
        .eff_lvl_o (eff_lvl)
    );

    irq_winner_pick #(.N_SRC(N_SRC)) u_pick (
        .elig_i    (elig),
        .eff_lvl_i (eff_lvl),
        .found_o   (found),
        .win_idx_o (win_idx),
        .win_lvl_o (win_lvl)
    );

    irq_vector_map #(.N_SRC(N_SRC), .N_EXT(N_EXT)) u_vec (
        .win_idx_i (win_idx),
        .win_lvl_i (win_lvl),
        .vec_o     (win_vec)
    );

    always_comb begin
        st_d     = st_q;
        st_d.req = found;
        st_d.lvl = found ? win_lvl : '0;
        st_d.vec = found ? win_vec : '0;
        // the take strobe acts on the winner the CPU currently sees
        if (take_i && st_q.req) begin
            st_d.mask = nest_mode_i ? st_q.lvl : TOP_LVL;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.req  <= 1'b0;
            st_q.lvl  <= '0;
            st_q.vec  <= '0;
            st_q.mask <= TOP_LVL;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_o      = st_q.req;
    assign req_lvl_o  = st_q.lvl;
    assign req_vec_o  = st_q.vec;
    assign new_mask_o = st_q.mask;
endmodule

// File: rtl/irq_prio_arbiter_chk.sv
module irq_prio_arbiter_chk
    import irq_arb_pkg::*;
#(
    parameter int N_SRC = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [N_SRC-1:0]     pend_i,
    input logic [LVL_W-1:0]     mask_i,
    input logic                 nest_mode_i,
    input logic                 take_i,
    input logic                 req_o,
    input logic [LVL_W-1:0]     req_lvl_o,
    input logic [VEC_W-1:0]     req_vec_o,
    input logic [LVL_W-1:0]     new_mask_o
);
    localparam logic [LVL_W-1:0] TOP_LVL = '1;

    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R2
    lvl_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> (req_lvl_o != '0));

    // R7 R8
    vec_format_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> ((req_vec_o[LVL_W-1:0] == req_lvl_o)
                   && ((req_vec_o == VEC_W'(EXT_VEC_BASE) + VEC_W'(req_lvl_o))
                       || (req_vec_o == VEC_W'(ONC_VEC_BASE) + VEC_W'(req_lvl_o)))));

    // R3
    mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && req_o) |-> ((req_lvl_o > $past(mask_i)) || (req_lvl_o == TOP_LVL)));

    // R6
    nmi_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(pend_i[N_SRC-1])) |-> (req_o && (req_lvl_o == TOP_LVL)));

    // R9
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && ($past(pend_i) == '0)) |-> (!req_o && (req_vec_o == '0)));

    // R10
    nest_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(take_i && req_o && nest_mode_i)) |-> (new_mask_o == $past(req_lvl_o)));

    // R11
    flat_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(take_i && req_o && !nest_mode_i)) |-> (new_mask_o == TOP_LVL));

    // R12
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(take_i && req_o)) |-> $stable(new_mask_o));
endmodule

bind irq_prio_arbiter irq_prio_arbiter_chk #(.N_SRC(N_SRC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pend_i      (pend_i),
    .mask_i      (mask_i),
    .nest_mode_i (nest_mode_i),
    .take_i      (take_i),
    .req_o       (req_o),
    .req_lvl_o   (req_lvl_o),
    .req_vec_o   (req_vec_o),
    .new_mask_o  (new_mask_o)
);

// File: tb/sim_irq_prio_arbiter.sv
`timescale 1ns/1ps
module sim_irq_prio_arbiter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pend_i = '0;
    logic [44:0] lvl_i = '0;
    logic [2:0]  mask_i = '0;
    logic        nest_mode_i = 1'b0;
    logic        take_i = 1'b0;
    logic        req_o;
    logic [2:0]  req_lvl_o;
    logic [7:0]  req_vec_o;
    logic [2:0]  new_mask_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    bit       exp_req = 1'b0;
    int       exp_lvl = 0;
    int       exp_vec = 0;
    int       exp_mask = 7;
    int unsigned seed = 32'h1234_5679;

    always #2 clk = ~clk;

    irq_prio_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .pend_i(pend_i), .lvl_i(lvl_i),
        .mask_i(mask_i), .nest_mode_i(nest_mode_i), .take_i(take_i),
        .req_o(req_o), .req_lvl_o(req_lvl_o), .req_vec_o(req_vec_o),
        .new_mask_o(new_mask_o)
    );

    function automatic int unsigned rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    // scan levels from 7 down, then indices from 15 down (R1 R3 R4 R5 R6)
    task automatic model(input logic [15:0] p, input logic [44:0] l, input int m,
                         output bit r, output int lv, output int v);
        r = 0; lv = 0; v = 0;
        for (int lev = 7; lev >= 1; lev--) begin
            for (int idx = 15; idx >= 0; idx--) begin
                int sl;
                sl = (idx == 15) ? 7 : int'(l[idx*3 +: 3]);
                if (!r && p[idx] && sl == lev && (lev > m || lev == 7)) begin
                    r = 1; lv = lev;
                    v = (idx >= 8) ? 24 + lev : 56 + lev;   // R7 R8
                end
            end
        end
    endtask

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // drive on falling edge, sample 1 ns after the rising edge (R9)
    task automatic step(input string tag, input logic [15:0] p, input logic [44:0] l,
                        input int m, input bit mode, input bit tk);
        bit r; int lv; int v;
        @(negedge clk);
        pend_i = p; lvl_i = l; mask_i = 3'(m); nest_mode_i = mode; take_i = tk;
        if (tk && exp_req) exp_mask = mode ? exp_lvl : 7;   // R10 R11 R12
        model(p, l, m, r, lv, v);
        @(posedge clk);
        #1;
        exp_req = r; exp_lvl = lv; exp_vec = v;
        check({tag, " req"}, int'(req_o), int'(r));
        check({tag, " lvl"}, int'(req_lvl_o), lv);
        check({tag, " vec"}, int'(req_vec_o), v);
        check({tag, " mask"}, int'(new_mask_o), exp_mask);
    endtask

    function automatic logic [44:0] all_lvl(input int lv);
        logic [44:0] x;
        for (int i = 0; i < 15; i++) x[i*3 +: 3] = 3'(lv);
        return x;
    endfunction

    initial begin
        #(4 * 190000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #7;
        check("R12 reset req", int'(req_o), 0);
        check("R12 reset lvl", int'(req_lvl_o), 0);
        check("R12 reset vec", int'(req_vec_o), 0);
        check("R12 reset mask", int'(new_mask_o), 7);
        @(negedge clk); rst_n = 1'b1;

        // R1 R2 R3 R6 R7 R8: single source, every level against every mask
        for (int s = 0; s < 16; s++)
            for (int lv = 0; lv < 8; lv++)
                for (int m = 0; m < 8; m++)
                    step("R2/R3/R6/R7/R8 single", 16'(1) << s, all_lvl(lv), m, 1'b0, 1'b0);

        // R5: equal levels, winner is the largest pending index below NMI
        for (int k = 0; k < 15; k++)
            step("R5 tie", 16'((32'd1 << (k + 1)) - 1), all_lvl(3), 0, 1'b0, 1'b0);

        // R4: mixed random patterns, no takes
        for (int t = 0; t < 3000; t++)
            step("R4 mixed", 16'(rnd()), {13'(rnd()), rnd()}, int'(rnd() % 8), 1'b0, 1'b0);

        // R10 R11 R12: takes in both modes, with and without a request
        for (int lv = 1; lv < 8; lv++) begin
            step("R10 setup", 16'h0100, all_lvl(lv), 0, 1'b1, 1'b0);
            step("R10 nest take", 16'h0100, all_lvl(lv), 0, 1'b1, 1'b1);
            step("R11 setup", 16'h0002, all_lvl(lv), 0, 1'b0, 1'b0);
            step("R11 flat take", 16'h0002, all_lvl(lv), 0, 1'b0, 1'b1);
            step("R12 idle", 16'h0000, all_lvl(lv), 0, 1'b1, 1'b0);
            step("R12 take without req", 16'h0000, all_lvl(lv), 0, 1'b1, 1'b1);
        end

        // R4 R10 R11 R12: random patterns with random takes and modes
        for (int t = 0; t < 3000; t++)
            step("R10/R11/R12 mixed", 16'(rnd()) & 16'(rnd()), {13'(rnd()), rnd()},
                 int'(rnd() % 8), rnd() % 2 == 0, rnd() % 3 == 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule